// File: doc/BRIEF.md
# Serial Port Status and Interrupt Front End

This block is the register and interrupt front end of an asynchronous serial port. It sits between a simple CPU register bus and the receive and transmit engines. The engines themselves (bit shifters, baud divider, parity logic) live elsewhere and reach this block only as single-cycle strobes: a byte has arrived, a framing error was seen, a parity error was seen, and the buffered transmit byte has been taken by the shifter.

Software sees two addresses. The control/status word carries read-only flags for receive data present, transmit buffer empty and three sticky error conditions, plus two interrupt enables and a write-only clear-errors command bit. The data address is shared: a read returns the held receive byte and a write fills the transmit buffer. Overrun is detected here, because only this block knows whether the previous byte was collected.

Two level-sensitive interrupt lines leave the block. The receive line covers both arriving data and all three error conditions under one enable. The transmit line signals that the buffer can accept another byte, which happens when the byte moves to the shifter, not when it has finished leaving the pin.

Top module: `uart_status_front`

## Requirements
- R1: After reset the status word at control address 0 reads 0x0800 (bit 11 transmit-empty set, every other bit 0) and both interrupt outputs are low.
- R2: A receive strobe while bit 12 is 0 stores the byte, sets status bit 12, and a read of data address 1 returns the byte in bits 7:0 with bits 15:8 zero.
- R3: A read of data address 1 clears status bit 12.
- R4: A receive strobe while bit 12 is 1 and no data read happens in that cycle sets the overrun flag at bit 14, discards the new byte and keeps the old one.
- R5: A framing error strobe sets bit 13 and a parity error strobe sets bit 15, each independently of the other.
- R6: Error bits 13, 14 and 15 stay set until a write to control address 0 with bit 10 = 1; data reads do not clear them, and an error strobe in the same cycle as the clear wins.
- R7: The receive interrupt is high exactly when enable bit 9 is 1 and any of status bits 12, 13, 14, 15 is 1.
- R8: A write to data address 1 loads the transmit byte output and clears bit 11; a transmit-move strobe sets bit 11 again.
- R9: The transmit interrupt is high exactly when enable bit 8 is 1 and status bit 11 is 1.
- R10: A control write changes only enables bits 9 and 8; writes to flag bits 15 to 11 have no effect and bit 10 always reads 0.
- R11: A receive strobe in the same cycle as a data read is accepted without overrun: the new byte is stored and bit 12 stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 4 | Register address (0 control/status, 1 data) |
| busWe | input | 1 | Write enable |
| busWdata | input | 16 | Write data |
| busRe | input | 1 | Read enable (read side effects) |
| busRdata | output | 16 | Read data for the addressed register |
| rxStrobe | input | 1 | Receive engine has a byte |
| rxByte | input | 8 | Received byte |
| frameErr | input | 1 | Framing error strobe |
| parityErr | input | 1 | Parity error strobe |
| txMove | input | 1 | Shifter has taken the transmit byte |
| txByte | output | 8 | Buffered transmit byte |
| rxIrq | output | 1 | Receive interrupt request (level) |
| txIrq | output | 1 | Transmit interrupt request (level) |

## Verification
The bench builds the block with its default parameters: a 4-bit address, 8-bit data, control at address 0 and data at address 1. Those values place every flag and enable at the bit positions named in the requirements, so each status comparison is a full 16-bit word and any misplaced or stray bit shows up. With one-byte receive holding, a second arriving byte reaches the overrun path directly, and the same-cycle read-and-receive case, the sticky error clear, and the move-versus-write transmit ordering are all driven from the table.

// File: rtl/uart_sr_pkg.sv
package uart_sr_pkg;
  localparam int BIT_PERR    = 15;
  localparam int BIT_OVR     = 14;
  localparam int BIT_FERR    = 13;
  localparam int BIT_RXFULL  = 12;
  localparam int BIT_TXEMPTY = 11;
  localparam int BIT_CLRERR  = 10;
  localparam int BIT_RIE     = 9;
  localparam int BIT_TIE     = 8;
  localparam int NUM_ERR     = 3;
  localparam int REG_W       = 16;

  typedef struct packed {
    logic selCtl;
    logic selData;
    logic ctlWr;
    logic dataWr;
    logic dataRd;
    logic errClr;
  } busStb_t;
endpackage

// File: rtl/uart_sr_ctl.sv
module uart_sr_ctl
  import uart_sr_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int CTL_ADDR  = 0,
  parameter int DATA_ADDR = 1
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic              busRe,
  input  logic [REG_W-1:0]  busWdata,
  output busStb_t           stb
);
  localparam logic [ADDR_W-1:0] CtlA  = ADDR_W'(CTL_ADDR);
  localparam logic [ADDR_W-1:0] DataA = ADDR_W'(DATA_ADDR);

  always_comb begin
    stb.selCtl  = (busAddr == CtlA);
    stb.selData = (busAddr == DataA);
    stb.ctlWr   = stb.selCtl && busWe;
    stb.dataWr  = stb.selData && busWe;
    stb.dataRd  = stb.selData && busRe;
    stb.errClr  = stb.ctlWr && busWdata[BIT_CLRERR];
  end
endmodule

// File: rtl/uart_sr_dp.sv
module uart_sr_dp
  import uart_sr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  busStb_t           stb,
  input  logic [REG_W-1:0]  busWdata,
  input  logic              rxStrobe,
  input  logic [DATA_W-1:0] rxByte,
  input  logic              frameErr,
  input  logic              parityErr,
  input  logic              txMove,
  output logic [REG_W-1:0]  statusWord,
  output logic [DATA_W-1:0] rxData,
  output logic [DATA_W-1:0] txData,
  output logic              rxIrq,
  output logic              txIrq
);
  localparam int ErrBase = BIT_FERR;

  logic rxFull, txEmpty, rxIe, txIe;
  logic [NUM_ERR-1:0] errFlag;  // [0]=framing [1]=overrun [2]=parity
  logic [NUM_ERR-1:0] errSet;
  logic acceptRx;

  assign acceptRx = rxStrobe && (!rxFull || stb.dataRd);
  assign errSet   = {parityErr, rxStrobe && rxFull && !stb.dataRd, frameErr};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxFull <= 1'b0;
      rxData <= '0;
    end else if (acceptRx) begin
      rxFull <= 1'b1;
      rxData <= rxByte;
    end else if (stb.dataRd) begin
      rxFull <= 1'b0;
    end
  end

  generate
    for (genvar e = 0; e < NUM_ERR; e++) begin : g_err
      always_ff @(posedge clk) begin
        if (!rstN) errFlag[e] <= 1'b0;
        else       errFlag[e] <= (errFlag[e] && !stb.errClr) || errSet[e];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txEmpty <= 1'b1;
      txData  <= '0;
    end else if (stb.dataWr) begin
      txEmpty <= 1'b0;
      txData  <= busWdata[DATA_W-1:0];
    end else if (txMove) begin
      txEmpty <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxIe <= 1'b0;
      txIe <= 1'b0;
    end else if (stb.ctlWr) begin
      rxIe <= busWdata[BIT_RIE];
      txIe <= busWdata[BIT_TIE];
    end
  end

  always_comb begin
    statusWord = '0;
    statusWord[ErrBase +: NUM_ERR] = errFlag;
    statusWord[BIT_RXFULL]  = rxFull;
    statusWord[BIT_TXEMPTY] = txEmpty;
    statusWord[BIT_RIE]     = rxIe;
    statusWord[BIT_TIE]     = txIe;
  end

  assign rxIrq = rxIe && (rxFull || (|errFlag));
  assign txIrq = txIe && txEmpty;
endmodule

// File: rtl/uart_status_front.sv
module uart_status_front
  import uart_sr_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 8,
  parameter int CTL_ADDR  = 0,
  parameter int DATA_ADDR = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [15:0]       busWdata,
  input  logic              busRe,
  output logic [15:0]       busRdata,
  input  logic              rxStrobe,
  input  logic [DATA_W-1:0] rxByte,
  input  logic              frameErr,
  input  logic              parityErr,
  input  logic              txMove,
  output logic [DATA_W-1:0] txByte,
  output logic              rxIrq,
  output logic              txIrq
);
  busStb_t stb;
  logic [REG_W-1:0]  statusWord;
  logic [DATA_W-1:0] rxData;

  uart_sr_ctl #(.ADDR_W(ADDR_W), .CTL_ADDR(CTL_ADDR), .DATA_ADDR(DATA_ADDR)) u_ctl (
    .busAddr(busAddr), .busWe(busWe), .busRe(busRe), .busWdata(busWdata), .stb(stb)
  );

  uart_sr_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .busWdata(busWdata),
    .rxStrobe(rxStrobe), .rxByte(rxByte), .frameErr(frameErr), .parityErr(parityErr),
    .txMove(txMove), .statusWord(statusWord), .rxData(rxData), .txData(txByte),
    .rxIrq(rxIrq), .txIrq(txIrq)
  );

  always_comb begin
    if (stb.selData)     busRdata = REG_W'(rxData);
    else if (stb.selCtl) busRdata = statusWord;
    else                 busRdata = '0;
  end
endmodule

// File: rtl/uart_status_front_chk.sv
module uart_status_front_chk #(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 8,
  parameter int DATA_ADDR = 1
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWe,
  input logic              busRe,
  input logic              rxStrobe,
  input logic              txMove,
  input logic              rxIrq,
  input logic              txIrq,
  input logic [15:0]       statusWord,
  input logic [DATA_W-1:0] rxData
);
  logic dRd, dWr;
  logic [2:0] errs;
  assign dRd  = busRe && (busAddr == ADDR_W'(DATA_ADDR));
  assign dWr  = busWe && (busAddr == ADDR_W'(DATA_ADDR));
  assign errs = statusWord[15:13];

  AST_RX_LOAD_SETS_FULL: assert property (@(posedge clk) disable iff (!rstN)
    rxStrobe |=> statusWord[12]); // R2
  AST_READ_CLEARS_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (dRd && !rxStrobe) |=> !statusWord[12]); // R3
  AST_OVERRUN_KEEPS_OLD: assert property (@(posedge clk) disable iff (!rstN)
    (rxStrobe && statusWord[12] && !dRd) |=> (statusWord[14] && $stable(rxData))); // R4
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (!(busWe && busAddr == '0)) |=> ((errs & $past(errs)) == $past(errs))); // R6
  AST_RXIRQ_GATED: assert property (@(posedge clk) disable iff (!rstN)
    !statusWord[9] |-> !rxIrq); // R7
  AST_TXEMPTY_ON_MOVE: assert property (@(posedge clk) disable iff (!rstN)
    (txMove && !dWr) |=> statusWord[11]); // R8
  AST_TXIRQ_GATED: assert property (@(posedge clk) disable iff (!rstN)
    !statusWord[11] |-> !txIrq); // R9
  AST_CLRBIT_READS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !statusWord[10]); // R10
endmodule

bind uart_status_front uart_status_front_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DATA_ADDR(DATA_ADDR)
) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busRe(busRe),
  .rxStrobe(rxStrobe), .txMove(txMove), .rxIrq(rxIrq), .txIrq(txIrq),
  .statusWord(statusWord), .rxData(rxData)
);

// File: tb/sim_uart_status_front.sv
module sim_uart_status_front;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 15;

  typedef struct packed {
    logic        rxS;
    logic [7:0]  rxB;
    logic        fe;
    logic        pe;
    logic        mv;
    logic        we;
    logic        re;
    logic [3:0]  addr;
    logic [15:0] wd;
    logic [15:0] expSt;
    logic        expRx;
    logic        expTx;
    logic [7:0]  req;
  } vec_t;

  // Each entry: stimulus for one cycle, then status/irqs expected afterwards.
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd0, 16'h0300, 16'h0B00, 1'b0, 1'b1, 8'd10}, // R10 enables on
    '{1'b1, 8'h5A, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 16'h0000, 16'h1B00, 1'b1, 1'b1, 8'd2},  // R2 byte in
    '{1'b1, 8'hA5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 16'h0000, 16'h5B00, 1'b1, 1'b1, 8'd4},  // R4 overrun
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd1, 16'h0000, 16'h4B00, 1'b1, 1'b1, 8'd3},  // R3 read clears full
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd0, 16'h0700, 16'h0B00, 1'b0, 1'b1, 8'd6},  // R6 clear errors
    '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 16'h0000, 16'h2B00, 1'b1, 1'b1, 8'd5},  // R5 framing
    '{1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd0, 16'h0000, 16'hAB00, 1'b1, 1'b1, 8'd5},  // R5 parity
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd1, 16'h0000, 16'hAB00, 1'b1, 1'b1, 8'd6},  // R6 read keeps errs
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd0, 16'h0400, 16'h0800, 1'b0, 1'b0, 8'd7},  // R7 irq off
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd1, 16'h0033, 16'h0000, 1'b0, 1'b0, 8'd8},  // R8 tx write
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd0, 16'h0100, 16'h0100, 1'b0, 1'b0, 8'd9},  // R9 tie, not empty
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0, 16'h0000, 16'h0900, 1'b0, 1'b1, 8'd9},  // R9 move -> irq
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd0, 16'hF800, 16'h0800, 1'b0, 1'b0, 8'd10}, // R10 flag writes ignored
    '{1'b1, 8'h11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 16'h0000, 16'h1800, 1'b0, 1'b0, 8'd7},  // R7 full, rie off
    '{1'b1, 8'h22, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd1, 16'h0000, 16'h1800, 1'b0, 1'b0, 8'd11}  // R11 read+rx
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] busAddr = '0;
  logic busWe = 1'b0, busRe = 1'b0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic rxStrobe = 1'b0, frameErr = 1'b0, parityErr = 1'b0, txMove = 1'b0;
  logic [7:0] rxByte = '0;
  logic [7:0] txByte;
  logic rxIrq, txIrq;
  int nCmp = 0, nBad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_status_front u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busWdata(busWdata),
    .busRe(busRe), .busRdata(busRdata), .rxStrobe(rxStrobe), .rxByte(rxByte),
    .frameErr(frameErr), .parityErr(parityErr), .txMove(txMove), .txByte(txByte),
    .rxIrq(rxIrq), .txIrq(txIrq)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: got 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  task automatic idle();
    busWe = 1'b0; busRe = 1'b0; busAddr = 4'd0; busWdata = '0;
    rxStrobe = 1'b0; rxByte = '0; frameErr = 1'b0; parityErr = 1'b0; txMove = 1'b0;
  endtask

  task automatic apply(input vec_t v);
    @(negedge clk);
    rxStrobe = v.rxS; rxByte = v.rxB; frameErr = v.fe; parityErr = v.pe; txMove = v.mv;
    busWe = v.we; busRe = v.re; busAddr = v.addr; busWdata = v.wd;
    @(posedge clk);
    #1 idle();
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 2000);
    nBad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    idle();
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    #1;
    check("R1 status after reset", busRdata, 16'h0800);
    check("R1 irqs after reset", {14'd0, rxIrq, txIrq}, 16'h0000);

    for (int i = 0; i < NVEC; i++) begin
      apply(VECS[i]);
      check($sformatf("R%0d vec%0d status", VECS[i].req, i), busRdata, VECS[i].expSt);
      check($sformatf("R%0d vec%0d irqs", VECS[i].req, i), {14'd0, rxIrq, txIrq},
            {14'd0, VECS[i].expRx, VECS[i].expTx});
    end

    // R11: the byte taken during the read cycle is the one now held
    busAddr = 4'd1; #1;
    check("R11 data after read+rx", busRdata, 16'h0022);
    check("R8 tx byte output", {8'd0, txByte}, 16'h0033);

    // R2 and R4: fresh byte, then overrun keeps the first byte
    apply('{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd1, 16'h0, 16'h0, 1'b0, 1'b0, 8'd3});
    apply('{1'b1, 8'h6C, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 16'h0, 16'h0, 1'b0, 1'b0, 8'd2});
    busAddr = 4'd1; #1;
    check("R2 read returns byte", busRdata, 16'h006C);
    apply('{1'b1, 8'h93, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 16'h0, 16'h0, 1'b0, 1'b0, 8'd4});
    busAddr = 4'd1; #1;
    check("R4 old byte kept", busRdata, 16'h006C);
    busAddr = 4'd0; #1;
    check("R4 overrun flag", busRdata, 16'h5800);

    // R6: error strobe in the same cycle as the clear command wins
    apply('{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 4'd0, 16'h0600, 16'h0, 1'b0, 1'b0, 8'd6});
    check("R6 set beats clear", busRdata, 16'h3A00);
    check("R7 rxIrq on framing", {15'd0, rxIrq}, 16'h0001);

    // R8: write and move in the same cycle leaves the buffer full
    apply('{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 4'd1, 16'h00C3, 16'h0, 1'b0, 1'b0, 8'd8});
    check("R8 write beats move", busRdata, 16'h3200);
    check("R8 tx byte updated", {8'd0, txByte}, 16'h00C3);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule